// File: doc/BRIEF.md
# Key-Protected Pin Routing Configuration Register

This block holds the configuration that routes two shared device pins to their I2C clock and data functions. It sits on a simple write-only register bus made of an address, write data and a one-cycle write strobe. An open configuration register can be written at any time. A second, guarded configuration register changes only through a fixed three-write ritual, so a single stray write from runaway software cannot move the pins.

The ritual is strict. An opening key value goes to one address. The new guarded value goes to the guarded address as the very next bus write. A closing key value goes to a third address as the write after that. The guarded value waits in a shadow register and reaches the live register only when the closing key arrives. Any break in the ritual drops the pending value. A break can be an unexpected address, a wrong key or a stray guarded write. After a break the sequencer returns to idle and an abort flag is raised. A later successful commit clears the flag. Idle bus cycles with no write do not count as a break.

Top module: `kpcr_top`

## Requirements
- R1: After reset, the open register, the live guarded register, the abort flag and both pin selects are all zero.
- R2: A write to the open register (address 0) appears on `open_cfg` in the cycle after the strobe, whatever state the key sequencer is in.
- R3: The writes key-1 (address 1, data 0x0007), guarded (address 2, any data) and key-2 (address 3, data 0x0013), as three consecutive bus writes, copy the guarded data to `lock_cfg` and clear `seq_abort`.
- R4: Between the guarded write and the key-2 write, `lock_cfg` keeps its previous value.
- R5: A key-2 write with any value other than 0x0013 in place of the closing key discards the pending value, leaves `lock_cfg` unchanged and sets `seq_abort`.
- R6: Any other bus write, to any address including unmapped addresses 4 to 7, between key-1 and the guarded write or between the guarded write and key-2 cancels the sequence and sets `seq_abort`. A cancelling write to the open register still takes effect.
- R7: A write to the guarded address that is not immediately preceded by a correct key-1 is ignored for `lock_cfg` and sets `seq_abort`.
- R8: A key-1 write with any value other than 0x0007 sets `seq_abort` and does not arm the sequencer, so a following guarded and key-2 pair leaves `lock_cfg` unchanged.
- R9: Cycles without a write strobe between the steps of the sequence do not cancel it.
- R10: `scl_i2c_sel` is high exactly when `open_cfg` bit 4 and `lock_cfg` bit 1 are both set. `sda_i2c_sel` is high exactly when `open_cfg` bit 12 and `lock_cfg` bit 1 are both set.
- R11: A key-2 write while the sequencer is idle has no effect on `lock_cfg` or `seq_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| open_cfg | output | 16 | Open configuration register |
| lock_cfg | output | 16 | Live guarded configuration register |
| seq_abort | output | 1 | Set by the latest broken sequence, cleared by a commit |
| scl_i2c_sel | output | 1 | Routes the clock pin to the I2C function |
| sda_i2c_sel | output | 1 | Routes the data pin to the I2C function |

## Verification
The hardest states to reach are the ones where the sequencer is armed or pending and a foreign write lands in exactly that one-write window. The only evidence of such a write is a missing commit and a raised flag. The bench walks every one of the eight addresses into both windows, and it sweeps opening and closing key values across wide ranges around the correct codes. For each case it predicts commit or abort from the rule alone. Gaps of idle cycles are mixed into correct sequences to show that only writes, not time, break the ritual.

// File: rtl/kpcr_pkg.sv
package kpcr_pkg;

    parameter int DATA_W = 16;
    parameter int ADDR_W = 3;
    parameter int N_PINS = 2;

    localparam logic [ADDR_W-1:0] A_OPEN = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(3);

    localparam logic [DATA_W-1:0] KEY1_VAL = DATA_W'(16'h0007);
    localparam logic [DATA_W-1:0] KEY2_VAL = DATA_W'(16'h0013);

    localparam int LOCK_EN_BIT = 1;

    // open-register bit that selects each pin: index 0 clock pin, 1 data pin
    function automatic int pin_open_bit(input int idx);
        return (idx == 0) ? 4 : 12;
    endfunction

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,
        SEQ_PENDING = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       abort;
    } seq_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] open_cfg;
        logic [DATA_W-1:0] shadow;
        logic [DATA_W-1:0] live;
    } cfg_regs_t;

endpackage

// File: rtl/kpcr_seq.sv
module kpcr_seq
    import kpcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              capture,
    output logic              commit,
    output logic              abort_flag
);

    seq_regs_t r_d, r_q;

    logic is_key1, is_lock, is_key2;
    logic key1_ok, key2_ok;

    always_comb begin
        is_key1 = (wr_addr == A_KEY1);
        is_lock = (wr_addr == A_LOCK);
        is_key2 = (wr_addr == A_KEY2);
        key1_ok = (wr_data == KEY1_VAL);
        key2_ok = (wr_data == KEY2_VAL);
    end

    always_comb begin
        logic brk;
        r_d     = r_q;
        capture = 1'b0;
        commit  = 1'b0;
        brk     = 1'b0;
        if (wr_en) begin
            unique case (r_q.state)
                SEQ_IDLE: begin
                    if (is_key1) begin
                        if (key1_ok) r_d.state = SEQ_ARMED;
                        else         brk = 1'b1;
                    end else if (is_lock) begin
                        brk = 1'b1;
                    end
                end
                SEQ_ARMED: begin
                    if (is_lock) begin
                        capture   = 1'b1;
                        r_d.state = SEQ_PENDING;
                    end else begin
                        brk = 1'b1;
                    end
                end
                SEQ_PENDING: begin
                    if (is_key2 && key2_ok) begin
                        commit    = 1'b1;
                        r_d.state = SEQ_IDLE;
                    end else begin
                        brk = 1'b1;
                    end
                end
                default: brk = 1'b1;
            endcase
        end
        if (brk) begin
            r_d.state = SEQ_IDLE;
            r_d.abort = 1'b1;
        end else if (commit) begin
            r_d.abort = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEQ_IDLE;
            r_q.abort <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign abort_flag = r_q.abort;

endmodule

// File: rtl/kpcr_regs.sv
module kpcr_regs
    import kpcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              capture,
    input  logic              commit,
    output logic [DATA_W-1:0] open_cfg,
    output logic [DATA_W-1:0] lock_cfg
);

    cfg_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en && (wr_addr == A_OPEN)) c_d.open_cfg = wr_data;
        if (capture)                      c_d.shadow   = wr_data;
        if (commit)                       c_d.live     = c_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign open_cfg = c_q.open_cfg;
    assign lock_cfg = c_q.live;

endmodule

// File: rtl/kpcr_route.sv
module kpcr_route
    import kpcr_pkg::*;
(
    input  logic [DATA_W-1:0] open_cfg,
    input  logic [DATA_W-1:0] lock_cfg,
    output logic [N_PINS-1:0] pin_sel
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        localparam int OB = pin_open_bit(i);
        assign pin_sel[i] = open_cfg[OB] & lock_cfg[LOCK_EN_BIT];
    end

endmodule

// File: rtl/kpcr_top.sv
module kpcr_top
    import kpcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] open_cfg,
    output logic [DATA_W-1:0] lock_cfg,
    output logic              seq_abort,
    output logic              scl_i2c_sel,
    output logic              sda_i2c_sel
);

    logic              capture, commit;
    logic [N_PINS-1:0] pin_sel;

    kpcr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .capture    (capture),
        .commit     (commit),
        .abort_flag (seq_abort)
    );

    kpcr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .capture  (capture),
        .commit   (commit),
        .open_cfg (open_cfg),
        .lock_cfg (lock_cfg)
    );

    kpcr_route u_route (
        .open_cfg (open_cfg),
        .lock_cfg (lock_cfg),
        .pin_sel  (pin_sel)
    );

    assign scl_i2c_sel = pin_sel[0];
    assign sda_i2c_sel = pin_sel[1];

endmodule

// File: rtl/kpcr_chk.sv
module kpcr_chk
    import kpcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] open_cfg,
    input logic [DATA_W-1:0] lock_cfg,
    input logic              seq_abort,
    input logic              scl_i2c_sel,
    input logic              sda_i2c_sel
);

    AST_LOCK_ONLY_ON_KEY2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_cfg) |-> $past(wr_en && wr_addr == A_KEY2 && wr_data == KEY2_VAL)); // R4

    AST_COMMIT_CLEARS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_cfg) |-> !seq_abort); // R3

    AST_ABORT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_abort) |-> $past(wr_en)); // R6

    AST_OPEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OPEN) |=> (open_cfg == $past(wr_data))); // R2

    AST_SCL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i2c_sel |-> (lock_cfg[LOCK_EN_BIT] && open_cfg[4])); // R10

    AST_SDA_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_i2c_sel |-> (lock_cfg[LOCK_EN_BIT] && open_cfg[12])); // R10

endmodule

bind kpcr_top kpcr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .open_cfg    (open_cfg),
    .lock_cfg    (lock_cfg),
    .seq_abort   (seq_abort),
    .scl_i2c_sel (scl_i2c_sel),
    .sda_i2c_sel (sda_i2c_sel)
);

// File: tb/kpcr_top_tb.sv
module kpcr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] open_cfg, lock_cfg;
    logic        seq_abort, scl_i2c_sel, sda_i2c_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_open = '0;
    logic [15:0] exp_lock = '0;
    logic        exp_flag = 1'b0;

    always #4 clk = ~clk;

    kpcr_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .open_cfg    (open_cfg),
        .lock_cfg    (lock_cfg),
        .seq_abort   (seq_abort),
        .scl_i2c_sel (scl_i2c_sel),
        .sda_i2c_sel (sda_i2c_sel)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "open_cfg", open_cfg, exp_open);
        check(req, "lock_cfg", lock_cfg, exp_lock);
        check(req, "seq_abort", 16'(seq_abort), 16'(exp_flag));
        // R10: pin selects from the expected register contents
        check(req, "scl_sel", 16'(scl_i2c_sel), 16'(exp_open[4] & exp_lock[1]));
        check(req, "sda_sel", 16'(sda_i2c_sel), 16'(exp_open[12] & exp_lock[1]));
    endtask

    // called at a negedge; leaves at the next negedge with the write applied
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd0) exp_open = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check_all("R1");

        // R2: open register sweep, including the pin-select bits
        for (int i = 0; i < 32; i++) begin
            wr(3'd0, 16'((i * 16'h1357) ^ (i[0] ? 16'h1010 : 16'h0000)));
            check_all("R2");
        end

        // R3 R4 R9: correct sequences, idle gaps on odd passes
        for (int i = 0; i < 24; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h0a53) | (i[1] ? 16'h0002 : 16'h0000);
            wr(3'd1, 16'h0007);
            if (i[0]) idle(i % 5 + 1);
            wr(3'd2, v);
            check_all("R4");
            if (i[0]) idle(2);
            wr(3'd3, 16'h0013);
            exp_lock = v;
            exp_flag = 1'b0;
            check_all(i[0] ? "R9" : "R3");
            wr(3'd0, 16'h1010 ^ 16'(i));
            check_all("R10");
        end

        // R5 R8: key value sweep
        for (int k1 = 0; k1 < 16; k1++) begin
            for (int k2 = 0; k2 < 32; k2++) begin
                logic [15:0] v;
                v = 16'((k1 << 8) | k2) ^ 16'h0002;
                wr(3'd1, 16'(k1));
                wr(3'd2, v);
                wr(3'd3, 16'(k2));
                if (k1 == 7 && k2 == 16'h13) begin
                    exp_lock = v;
                    exp_flag = 1'b0;
                end else begin
                    exp_flag = 1'b1;
                end
                check_all(k1 != 7 ? "R8" : "R5");
            end
        end

        // R6: a foreign write in either window, every address
        for (int pos = 0; pos < 2; pos++) begin
            for (int a = 0; a < 8; a++) begin
                wr(3'd1, 16'h0007);
                wr(3'd2, 16'h0002);
                wr(3'd3, 16'h0013);
                exp_lock = 16'h0002;
                exp_flag = 1'b0;
                check_all("R3");
                wr(3'd1, 16'h0007);
                if (pos == 0) wr(3'(a), 16'h55a8 ^ 16'(a));
                wr(3'd2, 16'hfff0);
                if (pos == 1) wr(3'(a), 16'h55a8 ^ 16'(a));
                wr(3'd3, 16'h0013);
                exp_flag = 1'b1;
                check_all("R6");
            end
        end

        // R7: direct guarded write
        wr(3'd2, 16'hbeef);
        check_all("R7");
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h0012);
        wr(3'd3, 16'h0013);
        exp_lock = 16'h0012;
        exp_flag = 1'b0;
        check_all("R3");
        wr(3'd2, 16'h0000);
        exp_flag = 1'b1;
        check_all("R7");

        // R11: closing key while idle
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h0006);
        wr(3'd3, 16'h0013);
        exp_lock = 16'h0006;
        exp_flag = 1'b0;
        wr(3'd3, 16'h0013);
        check_all("R11");
        wr(3'd3, 16'h0044);
        check_all("R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule